// File: doc/BRIEF.md
# Two-Channel DMA Control Registers with Interrupt Coalescing

This block holds the software-visible control state of a descriptor-driven DMA engine that has two channels. Each channel has four 32-bit registers: control, status, current-descriptor pointer and tail-descriptor pointer. Software reaches them through one register port. Channel 1 sits one fixed stride above channel 0. The block does not move data or fetch descriptors. It tells a separate data-mover when to run. From the data-mover it takes a one-cycle pulse for each finished packet and a pulse when the descriptor chain is used up.

Each channel coalesces its interrupts. A down-counter collects a programmable number of packet completions before it raises the completion interrupt. A delay timer raises a second interrupt once a programmable number of prescaled ticks has passed after the last packet. Software can read both counters back live from the status register, and each channel drives its own masked interrupt line.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, each channel's control reads 0x0001_0002 (threshold 1, bit 1 set) and its status reads 0x0001_0001 (halted bit 0, completion count 1). The halted outputs are high, and the run and interrupt outputs are low.
- R2: The channel is bit 0 of (address / 0x30), and the offset is address mod 0x30. Within a channel, control is at 0x00, status at 0x04, current descriptor at 0x08 and tail descriptor at 0x10. The two pointers read back what was written. Any other offset reads 0. A read returns its data one cycle later, marked by the read-valid output.
- R3: A control write with bit 2 set resets that channel: control goes back to its reset value and status goes back to halted only. Bit 2 always reads 0, and a run bit written together with bit 2 does not start the channel.
- R4: A control write with bit 0 set and bit 2 clear clears the halted and idle status bits. The run output follows control bit 0. Control bit 1 always reads 1.
- R5: Every control write loads the completion counter (status bits 23:16) from the written threshold field, control bits 23:16. This includes a write made in the middle of a count. A threshold of 0 acts as 256.
- R6: Each packet-complete pulse decrements the completion counter. A pulse that takes it from 1 to 0 sets the completion interrupt (status bit 12) and reloads the counter from the threshold.
- R7: A packet-complete pulse while the delay field (control bits 31:24) is nonzero restarts the delay timer (status bits 31:24) at that value. The timer then drops by one every PRESC clock cycles and stops at 0. Its step from 1 to 0 sets the delay interrupt (status bit 13) and reloads the completion counter.
- R8: Writing status clears each of bits 14:12 that is written as 1 and leaves each bit written as 0 unchanged.
- R9: A channel's interrupt output is high exactly when some status bit among 14:12 is set and the same bit of the control mask, bits 14:12, is also set.
- R10: A tail-descriptor write clears the idle status bit and gives a one-cycle start pulse on that channel's start output in the following cycle.
- R11: A chain-end pulse from the data-mover sets the channel's idle status bit (bit 1) and idle output.
- R12: The two channels are independent. Register writes and packet pulses on one channel never change the other channel's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| pkt_done | input | N_CHAN | Per-channel packet-complete pulse |
| chain_end | input | N_CHAN | Per-channel end-of-chain pulse from the data-mover |
| run | output | N_CHAN | Channel run bit |
| halted | output | N_CHAN | Channel halted status |
| idle | output | N_CHAN | Channel idle status |
| irq | output | N_CHAN | Masked channel interrupt |
| start | output | N_CHAN | One-cycle start request to the data-mover |

## Verification
The coalescing unit is tried with several packet patterns, and each one tells a different fault apart:
- A full threshold count separates a missing reload from an early interrupt.
- A count cut short by a new threshold written mid-way shows whether control writes reload the counter.
- A threshold of 0 checks for wrap-around instead of an immediate interrupt.
- A lone packet followed by silence shows whether the delay timer counts in prescaled ticks and reloads the counter when it expires.

Sweeping the interrupt mask over the same pending bits separates pending state from the line itself. Interleaving traffic on both channels exposes any decode fault that lets one channel reach into the other.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

   localparam int unsigned REG_W    = 32;
   localparam int unsigned FIELD_W  = 8;
   localparam int unsigned IRQ_N    = 3;

   // register offsets inside one channel window
   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_STAT = 4;
   localparam int unsigned OFS_CUR  = 8;
   localparam int unsigned OFS_TAIL = 16;

   // control bit positions
   localparam int unsigned B_RUN      = 0;
   localparam int unsigned B_TAILMODE = 1;
   localparam int unsigned B_SRST     = 2;
   localparam int unsigned B_IRQ_LO   = 12;
   localparam int unsigned B_THR_LO   = 16;
   localparam int unsigned B_DLY_LO   = 24;

   // stored control bits: run, mask, threshold, delay
   localparam logic [REG_W-1:0] CTRL_KEEP = 32'hFFFF_7001;
   localparam logic [REG_W-1:0] CTRL_RST  = 32'h0001_0000;
   localparam logic [FIELD_W-1:0] THR_RST = 8'd1;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_CTRL,
      RG_STAT,
      RG_CUR,
      RG_TAIL
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input int unsigned ofs);
      case (ofs)
         OFS_CTRL: return RG_CTRL;
         OFS_STAT: return RG_STAT;
         OFS_CUR:  return RG_CUR;
         OFS_TAIL: return RG_TAIL;
         default:  return RG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/dmactl_tick.sv
module dmactl_tick #(
   parameter int unsigned PRESC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   generate
      if (PRESC < 1) begin : g_bad
         $error("dmactl_tick: PRESC must be at least 1");
         assign tick = 1'b0;
      end else if (PRESC == 1) begin : g_every
         // every cycle is a tick, except the one that restarts the timer
         assign tick = !restart;
      end else begin : g_div
         localparam int unsigned PW = $clog2(PRESC);
         localparam logic [PW-1:0] PC_TOP = PW'(PRESC - 1);
         logic [PW-1:0] pc_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pc_q <= '0;
            else if (restart || pc_q == PC_TOP)
               pc_q <= '0;
            else
               pc_q <= pc_q + 1'b1;
         end

         assign tick = (pc_q == PC_TOP) && !restart;
      end
   endgenerate

endmodule

// File: rtl/dmactl_coalesce.sv
module dmactl_coalesce
   import dmactl_pkg::*;
#(
   parameter int unsigned PRESC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               load,
   input  logic [FIELD_W-1:0] load_thr,
   input  logic [FIELD_W-1:0] thresh,
   input  logic [FIELD_W-1:0] delay,
   input  logic               pkt,
   output logic [FIELD_W-1:0] cnt,
   output logic [FIELD_W-1:0] dly,
   output logic               ioc_set,
   output logic               dly_set
);

   logic [FIELD_W-1:0] cnt_q, dly_q;
   logic restart, tick, expire;

   assign restart = pkt && (delay != '0) && !clr;

   dmactl_tick #(.PRESC(PRESC)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart || clr),
      .tick    (tick)
   );

   assign expire  = tick && (dly_q == FIELD_W'(1)) && !restart && !clr;
   assign ioc_set = pkt && (cnt_q == FIELD_W'(1)) && !load && !clr;
   assign dly_set = expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= THR_RST;
         dly_q <= '0;
      end else if (clr) begin
         cnt_q <= THR_RST;
         dly_q <= '0;
      end else begin
         if (restart)
            dly_q <= delay;
         else if (tick && dly_q != '0)
            dly_q <= dly_q - 1'b1;

         if (load)
            cnt_q <= load_thr;
         else if (pkt)
            cnt_q <= (cnt_q == FIELD_W'(1)) ? thresh : cnt_q - 1'b1;
         else if (expire)
            cnt_q <= thresh;
      end
   end

   assign cnt = cnt_q;
   assign dly = dly_q;

   assert_ioc_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ioc_set |=> (cnt_q == $past(thresh)));

   assert_dly_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_q == '0 && !pkt && !clr) |=> (dly_q == '0));

   assert_dly_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dly_set |=> (dly_q == '0 && cnt_q == $past(thresh)));

endmodule

// File: rtl/dmactl_chan.sv
module dmactl_chan
   import dmactl_pkg::*;
#(
   parameter int unsigned PRESC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_sel_e         sel,
   input  logic [REG_W-1:0] wdata,
   input  logic             pkt_done,
   input  logic             chain_end,
   output logic [REG_W-1:0] rdata,
   output logic             run,
   output logic             halted,
   output logic             idle,
   output logic             irq,
   output logic             start
);

   logic [REG_W-1:0]   ctrl_q, cur_q, tail_q;
   logic [IRQ_N-1:0]   st_irq_q, w1c;
   logic               halted_q, idle_q, start_q;
   logic               wr_ctrl, wr_stat, wr_cur, wr_tail, srst, go;
   logic [FIELD_W-1:0] cnt, dly;
   logic               ioc_set, dly_set;

   assign wr_ctrl = wr_en && (sel == RG_CTRL);
   assign wr_stat = wr_en && (sel == RG_STAT);
   assign wr_cur  = wr_en && (sel == RG_CUR);
   assign wr_tail = wr_en && (sel == RG_TAIL);
   assign srst    = wr_ctrl && wdata[B_SRST];
   assign go      = wr_ctrl && !wdata[B_SRST] && wdata[B_RUN];
   assign w1c     = wr_stat ? wdata[B_IRQ_LO +: IRQ_N] : '0;

   dmactl_coalesce #(.PRESC(PRESC)) u_coal (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (srst),
      .load     (wr_ctrl),
      .load_thr (wdata[B_THR_LO +: FIELD_W]),
      .thresh   (ctrl_q[B_THR_LO +: FIELD_W]),
      .delay    (ctrl_q[B_DLY_LO +: FIELD_W]),
      .pkt      (pkt_done),
      .cnt      (cnt),
      .dly      (dly),
      .ioc_set  (ioc_set),
      .dly_set  (dly_set)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RST;
         cur_q    <= '0;
         tail_q   <= '0;
         st_irq_q <= '0;
         halted_q <= 1'b1;
         idle_q   <= 1'b0;
         start_q  <= 1'b0;
      end else begin
         start_q <= wr_tail;
         if (wr_cur)  cur_q  <= wdata;
         if (wr_tail) tail_q <= wdata;
         if (srst) begin
            ctrl_q   <= CTRL_RST;
            st_irq_q <= '0;
            halted_q <= 1'b1;
            idle_q   <= 1'b0;
         end else begin
            if (wr_ctrl) ctrl_q <= wdata & CTRL_KEEP;
            if (go)      halted_q <= 1'b0;
            if (chain_end)
               idle_q <= 1'b1;
            else if (go || wr_tail)
               idle_q <= 1'b0;
            st_irq_q <= (st_irq_q & ~w1c) | {1'b0, dly_set, ioc_set};
         end
      end
   end

   always_comb begin
      case (sel)
         RG_CTRL: rdata = ctrl_q | (REG_W'(1) << B_TAILMODE);
         RG_STAT: rdata = {dly, cnt, 1'b0, st_irq_q, 10'b0, idle_q, halted_q};
         RG_CUR:  rdata = cur_q;
         RG_TAIL: rdata = tail_q;
         default: rdata = '0;
      endcase
   end

   assign run    = ctrl_q[B_RUN];
   assign halted = halted_q;
   assign idle   = idle_q;
   assign start  = start_q;
   assign irq    = |(st_irq_q & ctrl_q[B_IRQ_LO +: IRQ_N]);

   assert_srst_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (halted && !run && !idle && !irq));

   assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl_q[B_IRQ_LO +: IRQ_N] != '0));

   assert_tail_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tail && !chain_end) |=> (start && !idle));

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
   import dmactl_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_CHAN = 2,
   parameter int unsigned STRIDE = 48,
   parameter int unsigned PRESC  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              reg_rvalid,
   input  logic [N_CHAN-1:0] pkt_done,
   input  logic [N_CHAN-1:0] chain_end,
   output logic [N_CHAN-1:0] run,
   output logic [N_CHAN-1:0] halted,
   output logic [N_CHAN-1:0] idle,
   output logic [N_CHAN-1:0] irq,
   output logic [N_CHAN-1:0] start
);

   localparam int unsigned CH_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1;

   generate
      if (N_CHAN < 2 || (N_CHAN & (N_CHAN - 1)) != 0) begin : g_chk_chan
         $error("dma_chan_ctl: N_CHAN must be a power of two, at least 2");
      end
      if (STRIDE < OFS_TAIL + 4 || STRIDE % 4 != 0) begin : g_chk_stride
         $error("dma_chan_ctl: STRIDE must be word aligned and cover all registers");
      end
      if (STRIDE * N_CHAN > (1 << ADDR_W)) begin : g_chk_addr
         $error("dma_chan_ctl: ADDR_W too small for all channels");
      end
   endgenerate

   logic [CH_W-1:0]   ch_sel;
   logic [ADDR_W-1:0] ofs;
   reg_sel_e          sel;
   logic [REG_W-1:0]  chan_rd [N_CHAN];

   assign ch_sel = CH_W'((reg_addr / ADDR_W'(STRIDE)) % ADDR_W'(N_CHAN));
   assign ofs    = reg_addr % ADDR_W'(STRIDE);
   assign sel    = decode_ofs(32'(ofs));

   for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
      dmactl_chan #(.PRESC(PRESC)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (reg_wr && (ch_sel == CH_W'(g))),
         .sel       (sel),
         .wdata     (reg_wdata),
         .pkt_done  (pkt_done[g]),
         .chain_end (chain_end[g]),
         .rdata     (chan_rd[g]),
         .run       (run[g]),
         .halted    (halted[g]),
         .idle      (idle[g]),
         .irq       (irq[g]),
         .start     (start[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd) reg_rdata <= chan_rd[ch_sel];
      end
   end

   assert_rvalid_follows_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;

   localparam int unsigned PRESC = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr, reg_rd;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        reg_rvalid;
   logic [1:0]  pkt_done, chain_end, run, halted, idle, irq, start;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   dma_chan_ctl #(.ADDR_W(8), .N_CHAN(2), .STRIDE(48), .PRESC(PRESC)) i_dma_chan_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid),
      .pkt_done   (pkt_done),
      .chain_end  (chain_end),
      .run        (run),
      .halted     (halted),
      .idle       (idle),
      .irq        (irq),
      .start      (start)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // monitor: pop the expected read data as results appear
   always @(negedge clk) begin
      logic [31:0] e;
      string t;
      if (rst_n === 1'b1 && reg_rvalid === 1'b1) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 scoreboard: actual %h expected no read", reg_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, reg_rdata, e);
         end
      end
   end

   // driver tasks: called just after a falling edge, return after the next one
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pkt(input int ch);
      pkt_done[ch] = 1'b1;
      @(negedge clk);
      pkt_done = '0;
   endtask

   task automatic cend(input int ch);
      chain_end[ch] = 1'b1;
      @(negedge clk);
      chain_end = '0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      pkt_done = '0; chain_end = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 halted", 32'(halted), 32'h3);
      check("R1 run", 32'(run), 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      rd(8'h00, 32'h0001_0002, "R1 ctrl ch0");
      rd(8'h04, 32'h0001_0001, "R1 stat ch0");
      rd(8'h34, 32'h0001_0001, "R1 stat ch1");

      // R2 address map
      wr(8'h08, 32'h1000_0040);
      wr(8'h38, 32'hCAFE_0000);
      rd(8'h08, 32'h1000_0040, "R2 cur ch0");
      rd(8'h38, 32'hCAFE_0000, "R2 cur ch1");
      rd(8'h0C, 32'h0000_0000, "R2 unmapped");
      rd(8'h68, 32'h1000_0040, "R2 mirror ch0");

      // R4 run, R12 other channel untouched
      wr(8'h00, 32'h0003_7001);
      check("R4 halted ch0", 32'(halted[0]), 32'h0);
      check("R4 run ch0", 32'(run[0]), 32'h1);
      check("R12 halted ch1", 32'(halted[1]), 32'h1);
      rd(8'h00, 32'h0003_7003, "R4 ctrl readback");
      rd(8'h04, 32'h0003_0000, "R4 stat after run");

      // R6 threshold of three
      pkt(0);
      pkt(0);
      rd(8'h04, 32'h0001_0000, "R6 count after two");
      check("R6 irq before threshold", 32'(irq[0]), 32'h0);
      pkt(0);
      rd(8'h04, 32'h0003_1000, "R6 ioc and reload");
      check("R9 irq unmasked", 32'(irq[0]), 32'h1);

      // R8 write-one-to-clear
      wr(8'h04, 32'h0000_2000);
      rd(8'h04, 32'h0003_1000, "R8 other bit kept");
      wr(8'h04, 32'h0000_1000);
      rd(8'h04, 32'h0003_0000, "R8 ioc cleared");
      check("R8 irq dropped", 32'(irq[0]), 32'h0);

      // R9 mask
      wr(8'h00, 32'h0001_0001);
      pkt(0);
      rd(8'h04, 32'h0001_1000, "R9 pending while masked");
      check("R9 irq masked", 32'(irq[0]), 32'h0);
      wr(8'h00, 32'h0001_1001);
      check("R9 irq after unmask", 32'(irq[0]), 32'h1);
      wr(8'h04, 32'h0000_1000);

      // R5 reload mid-count and threshold zero
      wr(8'h00, 32'h0005_0001);
      pkt(0);
      rd(8'h04, 32'h0004_0000, "R5 mid count");
      wr(8'h00, 32'h0006_0001);
      rd(8'h04, 32'h0006_0000, "R5 reload on write");
      wr(8'h00, 32'h0000_0001);
      pkt(0);
      rd(8'h04, 32'h00FF_0000, "R5 threshold zero wraps");

      // R7 delay timer: 3 ticks of PRESC cycles
      wr(8'h00, 32'h0314_2001);
      pkt(0);
      rd(8'h04, 32'h0313_0000, "R7 timer loaded");
      wait_cyc(3 * PRESC - 3);
      check("R7 no early expiry", 32'(irq[0]), 32'h0);
      wait_cyc(4);
      check("R7 delay irq", 32'(irq[0]), 32'h1);
      rd(8'h04, 32'h0014_2000, "R7 expiry reloads count");
      wr(8'h04, 32'h0000_2000);

      // R3 soft reset with run
      wr(8'h00, 32'h0005_0005);
      check("R3 halted", 32'(halted[0]), 32'h1);
      check("R3 run blocked", 32'(run[0]), 32'h0);
      rd(8'h00, 32'h0001_0002, "R3 ctrl after reset");
      rd(8'h04, 32'h0001_0001, "R3 stat after reset");

      // R11 idle, R10 tail start on channel 1
      wr(8'h30, 32'h0001_0001);
      check("R4 halted ch1", 32'(halted[1]), 32'h0);
      cend(1);
      check("R11 idle ch1", 32'(idle[1]), 32'h1);
      rd(8'h34, 32'h0001_0002, "R11 idle status bit");
      wr(8'h40, 32'h0000_0180);
      check("R10 start ch1", 32'(start), 32'h2);
      check("R10 idle cleared", 32'(idle[1]), 32'h0);
      wait_cyc(1);
      check("R10 start one cycle", 32'(start), 32'h0);
      rd(8'h40, 32'h0000_0180, "R10 tail readback");
      cend(1);
      wr(8'h30, 32'h0001_0001);
      check("R4 run clears idle", 32'(idle[1]), 32'h0);

      // R12 independence
      pkt(1);
      rd(8'h04, 32'h0001_0001, "R12 ch0 untouched");
      rd(8'h34, 32'h0001_1000, "R12 ch1 ioc");
      check("R12 irq lines", 32'(irq), 32'h0);

      wait_cyc(3);
      if (exp_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 scoreboard: actual %0d reads pending expected 0", exp_q.size());
      end
      report();
      $finish;
   end

endmodule